// File: doc/BRIEF.md
# Display Fetch Bus-Takeover Sequencer

This block lets a display controller borrow the memory bus of a small 8-bit processor for a while. For each display phase it runs a fixed, tick-counted sequence. An acquire phase raises the processor's active-high disable line so that the processor leaves the bus. A set number of ticks later it turns on the address drivers. A few ticks after that it starts a burst of active-low read strobes that fetch display bytes. A release phase floats the address bus first, waits a set number of ticks, and only then hands the disable line back to the processor.

All delays are whole ticks of an external strobe (`tick`). In the target system this strobe fires every 250 ns, one system clock wide. Each of the eight phase codes has its own delays, so the processor is always evicted cleanly, whatever display region comes next. The bus stays taken between an acquire phase and the release phase that follows it. During that time the controller does its own rendering. Pixel shifting, sync and character generation are handled elsewhere.

Top module: `vdma_bus_seq`

## Requirements
- R1: After reset, `cpu_disable` is 0, `addr_oe` is 0, `rd_n` is 1, and `busy`, `data_valid` and `err` are 0.
- R2: A command is taken only on a clock edge where `cmd_valid`, `tick` and idle (`busy` low) are all true. A `cmd_valid` without `tick`, or during a running phase, is ignored and leaves the outputs and the running phase unchanged.
- R3: Phase codes on `cmd_phase`: bit 0 set means release, bit 0 clear means acquire. Bits 2:1 select the region: 0 pre-charge, 1 main display, 2 text, 3 graphics.
- R4: On an acquire, `cpu_disable` is high from the accepting edge (tick 0), and `addr_oe` turns on at tick 15, 21, 14 or 18 for region 0, 1, 2 or 3.
- R5: On an acquire, the first `rd_n` fall comes at tick 25, 100, 34 or 38 for region 0 to 3. Each strobe is low for exactly 2 ticks, with one high tick between strobes. The burst has `cmd_count`+1 strobes.
- R6: While strobe k (counting from 0) is low, `addr_bus` equals `cmd_addr`+k.
- R7: On the tick where strobe k rises, `data_out` takes `rd_data`, and `data_valid` is high for exactly that one clock.
- R8: On a release, `addr_oe` goes low at the accepting edge, and `cpu_disable` falls at tick 21, 13, 9 or 13 for region 0, 1, 2 or 3.
- R9: `busy` is high from the accepting edge until the edge of the last strobe rise (acquire) or of the `cpu_disable` fall (release), and is low from that edge on.
- R10: `addr_oe` is never high while `cpu_disable` is low. If that ever happened, `err` would rise and stay high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-clock timing strobe, one per 250 ns tick |
| cmd_valid | input | 1 | Start-of-phase command request |
| cmd_phase | input | 3 | Phase code (R3) |
| cmd_addr | input | ADDR_W | First fetch address for an acquire |
| cmd_count | input | LEN_W | Number of reads minus one |
| rd_data | input | DATA_W | Memory read data |
| cpu_disable | output | 1 | Active-high processor bus disable |
| rd_n | output | 1 | Active-low read strobe |
| addr_bus | output | ADDR_W | Address bus value |
| addr_oe | output | 1 | Address bus output enable |
| data_out | output | DATA_W | Captured read data |
| data_valid | output | 1 | One-clock pulse when data_out is new |
| busy | output | 1 | Phase in progress |
| err | output | 1 | Sticky bus-contention flag |

## Verification
The bench uses the default parameters: the delays listed above, 16-bit addresses, 8-bit data, a 4-bit count and an 8-bit tick counter. With these, the longest burst of 16 strobes after the 100-tick main-region start fits inside the counter range. The bench varies the number of idle clocks between ticks, so the check that timing depends only on ticks and not on clock count is exercised. The sticky setting of the error flag is the one built, so any contention during the run would still show at the end.

// File: rtl/vdma_pkg.sv
`timescale 1ns/1ps
package vdma_pkg;
   typedef enum logic [2:0] {
      PH_PRE_ACQ  = 3'd0,
      PH_PRE_REL  = 3'd1,
      PH_MAIN_ACQ = 3'd2,
      PH_MAIN_REL = 3'd3,
      PH_TXT_ACQ  = 3'd4,
      PH_TXT_REL  = 3'd5,
      PH_GFX_ACQ  = 3'd6,
      PH_GFX_REL  = 3'd7
   } phase_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ACQ  = 2'd1,
      ST_REL  = 2'd2
   } state_e;

   function automatic logic is_release(input phase_e p);
      return p[0];
   endfunction

   function automatic logic [1:0] region_of(input phase_e p);
      return p[2:1];
   endfunction
endpackage

// File: rtl/vdma_phase_rom.sv
`timescale 1ns/1ps
module vdma_phase_rom
   import vdma_pkg::*;
#(
   parameter int CNT_W     = 8,
   parameter int LEN_W     = 4,
   parameter int PRE_DRV   = 15,
   parameter int PRE_FST   = 25,
   parameter int PRE_REL   = 21,
   parameter int MAIN_DRV  = 21,
   parameter int MAIN_FST  = 100,
   parameter int MAIN_REL  = 13,
   parameter int TXT_DRV   = 14,
   parameter int TXT_FST   = 34,
   parameter int TXT_REL   = 9,
   parameter int GFX_DRV   = 18,
   parameter int GFX_FST   = 38,
   parameter int GFX_REL   = 13
) (
   input  phase_e             ph,
   output logic [CNT_W-1:0]   drive_t,
   output logic [CNT_W-1:0]   first_t,
   output logic [CNT_W-1:0]   rel_t
);
   localparam int NREG = 4;
   localparam int DRV [NREG] = '{PRE_DRV, MAIN_DRV, TXT_DRV, GFX_DRV};
   localparam int FST [NREG] = '{PRE_FST, MAIN_FST, TXT_FST, GFX_FST};
   localparam int REL [NREG] = '{PRE_REL, MAIN_REL, TXT_REL, GFX_REL};
   localparam int TMAX = (1 << CNT_W) - 1;
   localparam int BURST = 3 * (1 << LEN_W);

   for (genvar g = 0; g < NREG; g++) begin : g_chk
      if (DRV[g] < 1) begin : g_bad_drv
         $error("address drive delay must be at least one tick");
      end
      if (FST[g] <= DRV[g]) begin : g_bad_fst
         $error("first read must follow address drive");
      end
      if (REL[g] < 1 || REL[g] > TMAX) begin : g_bad_rel
         $error("release delay out of counter range");
      end
      if (FST[g] + BURST > TMAX) begin : g_bad_len
         $error("counter too narrow for longest burst");
      end
   end

   logic [1:0] rg;
   assign rg      = region_of(ph);
   assign drive_t = CNT_W'(DRV[rg]);
   assign first_t = CNT_W'(FST[rg]);
   assign rel_t   = CNT_W'(REL[rg]);
endmodule

// File: rtl/vdma_tick_timer.sv
`timescale 1ns/1ps
module vdma_tick_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             clear,
   input  logic             run,
   output logic [CNT_W-1:0] t_now
);
   localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clear) begin
         cnt <= '0;
      end else if (run && tick && cnt != SAT - 1'b1) begin
         cnt <= cnt + 1'b1;
      end
   end

   // tick number being reached at this tick edge
   assign t_now = cnt + 1'b1;
endmodule

// File: rtl/vdma_read_engine.sv
`timescale 1ns/1ps
module vdma_read_engine #(
   parameter int CNT_W  = 8,
   parameter int LEN_W  = 4,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              start,
   input  logic              active,
   input  logic [CNT_W-1:0]  t_now,
   input  logic [CNT_W-1:0]  first_t,
   input  logic [LEN_W-1:0]  count_in,
   input  logic [DATA_W-1:0] rd_data,
   output logic              rd_n,
   output logic [LEN_W-1:0]  idx,
   output logic [DATA_W-1:0] data_q,
   output logic              valid,
   output logic              done
);
   typedef enum logic [1:0] {
      SL_WAIT = 2'd0,
      SL_LOW1 = 2'd1,
      SL_LOW2 = 2'd2,
      SL_GAP  = 2'd3
   } slot_e;

   slot_e            slot;
   logic [LEN_W-1:0] last;

   assign done = active && tick && slot == SL_LOW2 && idx == last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot   <= SL_WAIT;
         idx    <= '0;
         last   <= '0;
         rd_n   <= 1'b1;
         data_q <= '0;
         valid  <= 1'b0;
      end else begin
         valid <= 1'b0;
         if (start) begin
            slot <= SL_WAIT;
            idx  <= '0;
            last <= count_in;
            rd_n <= 1'b1;
         end else if (active && tick) begin
            unique case (slot)
               SL_WAIT: begin
                  if (t_now == first_t) begin
                     rd_n <= 1'b0;
                     slot <= SL_LOW1;
                  end
               end
               SL_LOW1: slot <= SL_LOW2;
               SL_LOW2: begin
                  rd_n   <= 1'b1;
                  data_q <= rd_data;
                  valid  <= 1'b1;
                  if (idx == last) begin
                     slot <= SL_WAIT;
                  end else begin
                     idx  <= idx + 1'b1;
                     slot <= SL_GAP;
                  end
               end
               SL_GAP: begin
                  rd_n <= 1'b0;
                  slot <= SL_LOW1;
               end
               default: slot <= SL_WAIT;
            endcase
         end
      end
   end
endmodule

// File: rtl/vdma_bus_seq.sv
`timescale 1ns/1ps
module vdma_bus_seq
   import vdma_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 8,
   parameter int LEN_W      = 4,
   parameter int CNT_W      = 8,
   parameter bit ERR_STICKY = 1'b1,
   parameter int PRE_DRV    = 15,
   parameter int PRE_FST    = 25,
   parameter int PRE_REL    = 21,
   parameter int MAIN_DRV   = 21,
   parameter int MAIN_FST   = 100,
   parameter int MAIN_REL   = 13,
   parameter int TXT_DRV    = 14,
   parameter int TXT_FST    = 34,
   parameter int TXT_REL    = 9,
   parameter int GFX_DRV    = 18,
   parameter int GFX_FST    = 38,
   parameter int GFX_REL    = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_phase,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [LEN_W-1:0]  cmd_count,
   input  logic [DATA_W-1:0] rd_data,
   output logic              cpu_disable,
   output logic              rd_n,
   output logic [ADDR_W-1:0] addr_bus,
   output logic              addr_oe,
   output logic [DATA_W-1:0] data_out,
   output logic              data_valid,
   output logic              busy,
   output logic              err
);
   if (ADDR_W < LEN_W) begin : g_bad_aw
      $error("address narrower than burst index");
   end
   if (DATA_W < 1) begin : g_bad_dw
      $error("data width must be positive");
   end

   state_e            state;
   phase_e            ph_q;
   logic [ADDR_W-1:0] base_q;
   logic [CNT_W-1:0]  t_now, drive_t, first_t, rel_t;
   logic [LEN_W-1:0]  idx;
   logic              accept, acq_start, burst_done, viol;

   assign accept    = cmd_valid && tick && state == ST_IDLE;
   assign acq_start = accept && !is_release(phase_e'(cmd_phase));

   vdma_phase_rom #(
      .CNT_W(CNT_W), .LEN_W(LEN_W),
      .PRE_DRV(PRE_DRV), .PRE_FST(PRE_FST), .PRE_REL(PRE_REL),
      .MAIN_DRV(MAIN_DRV), .MAIN_FST(MAIN_FST), .MAIN_REL(MAIN_REL),
      .TXT_DRV(TXT_DRV), .TXT_FST(TXT_FST), .TXT_REL(TXT_REL),
      .GFX_DRV(GFX_DRV), .GFX_FST(GFX_FST), .GFX_REL(GFX_REL)
   ) u_rom (
      .ph(ph_q), .drive_t(drive_t), .first_t(first_t), .rel_t(rel_t)
   );

   vdma_tick_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .clear(accept), .run(state != ST_IDLE), .t_now(t_now)
   );

   vdma_read_engine #(.CNT_W(CNT_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .start(acq_start), .active(state == ST_ACQ),
      .t_now(t_now), .first_t(first_t), .count_in(cmd_count),
      .rd_data(rd_data), .rd_n(rd_n), .idx(idx),
      .data_q(data_out), .valid(data_valid), .done(burst_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         ph_q        <= PH_PRE_ACQ;
         base_q      <= '0;
         cpu_disable <= 1'b0;
         addr_oe     <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (accept) begin
                  ph_q <= phase_e'(cmd_phase);
                  if (is_release(phase_e'(cmd_phase))) begin
                     state   <= ST_REL;
                     addr_oe <= 1'b0;
                  end else begin
                     state       <= ST_ACQ;
                     cpu_disable <= 1'b1;
                     base_q      <= cmd_addr;
                  end
               end
            end
            ST_ACQ: begin
               if (tick && t_now == drive_t) addr_oe <= 1'b1;
               if (burst_done) state <= ST_IDLE;
            end
            ST_REL: begin
               if (tick && t_now == rel_t) begin
                  cpu_disable <= 1'b0;
                  state       <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign addr_bus = base_q + ADDR_W'(idx);
   assign busy     = state != ST_IDLE;
   assign viol     = addr_oe && !cpu_disable;

   if (ERR_STICKY) begin : g_err_sticky
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) err <= 1'b0;
         else        err <= err | viol;
      end
   end else begin : g_err_live
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) err <= 1'b0;
         else        err <= viol;
      end
   end
endmodule

// File: rtl/vdma_bus_seq_chk.sv
`timescale 1ns/1ps
module vdma_bus_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic cpu_disable,
   input logic rd_n,
   input logic addr_oe,
   input logic data_valid,
   input logic busy,
   input logic err
);
   assert_oe_needs_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      addr_oe |-> cpu_disable);

   assert_no_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !err);

   assert_strobe_needs_oe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> addr_oe);

   assert_valid_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid |-> $rose(rd_n));

   assert_release_ends_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cpu_disable) |-> !busy);

   assert_strobe_while_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_n) |-> busy);
endmodule

bind vdma_bus_seq vdma_bus_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_disable(cpu_disable), .rd_n(rd_n),
   .addr_oe(addr_oe), .data_valid(data_valid), .busy(busy), .err(err)
);

// File: tb/vdma_bus_seq_test.sv
`timescale 1ns/1ps
module vdma_bus_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_phase = 3'd0;
   logic [15:0] cmd_addr = '0;
   logic [3:0]  cmd_count = '0;
   logic [7:0]  rd_data;
   logic        cpu_disable, rd_n, addr_oe, data_valid, busy, err;
   logic [15:0] addr_bus;
   logic [7:0]  data_out;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   function automatic logic [7:0] memf(input logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h5A;
   endfunction
   assign rd_data = memf(addr_bus);

   vdma_bus_seq uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_valid(cmd_valid),
      .cmd_phase(cmd_phase), .cmd_addr(cmd_addr), .cmd_count(cmd_count),
      .rd_data(rd_data), .cpu_disable(cpu_disable), .rd_n(rd_n),
      .addr_bus(addr_bus), .addr_oe(addr_oe), .data_out(data_out),
      .data_valid(data_valid), .busy(busy), .err(err)
   );

   function automatic int exp_drive(input logic [2:0] p);
      case (p[2:1]) 2'd0: return 15; 2'd1: return 21; 2'd2: return 14; default: return 18; endcase
   endfunction
   function automatic int exp_first(input logic [2:0] p);
      case (p[2:1]) 2'd0: return 25; 2'd1: return 100; 2'd2: return 34; default: return 38; endcase
   endfunction
   function automatic int exp_rel(input logic [2:0] p);
      case (p[2:1]) 2'd0: return 21; 2'd1: return 13; 2'd2: return 9; default: return 13; endcase
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // one tick: inputs set at a falling edge, outputs sampled at the next one
   task automatic tk(input bit cv, input logic [2:0] ph, input logic [15:0] a, input logic [3:0] n);
      @(negedge clk);
      tick = 1'b1; cmd_valid = cv; cmd_phase = ph; cmd_addr = a; cmd_count = n;
      @(negedge clk);
      tick = 1'b0; cmd_valid = 1'b0;
   endtask

   task automatic gap();
      repeat ($urandom % 3) @(negedge clk);
   endtask

   task automatic run_acq(input logic [2:0] ph, input logic [15:0] a, input logic [3:0] n, input bit noise);
      int d, f, fend;
      d = exp_drive(ph); f = exp_first(ph); fend = f + 3 * int'(n) + 2;
      tk(1'b1, ph, a, n);
      chk(cpu_disable == 1'b1, "R4 disable at accept", int'(cpu_disable), 1);
      chk(addr_oe == 1'b0, "R4 oe off at accept", int'(addr_oe), 0);
      chk(busy == 1'b1, "R9 busy at accept", int'(busy), 1);
      for (int t = 1; t <= fend; t++) begin
         int k, m;
         bit lo, vv;
         gap();
         tk(noise && ($urandom % 4 == 0), 3'($urandom), 16'($urandom), 4'($urandom));
         k  = (t >= f) ? (t - f) / 3 : 0;
         m  = (t >= f) ? (t - f) % 3 : 0;
         lo = (t >= f) && (m != 2);
         vv = (t >= f) && (m == 2);
         chk(addr_oe == (t >= d), "R4 oe timing", int'(addr_oe), int'(t >= d));
         chk(rd_n == !lo, "R5 strobe timing", int'(rd_n), int'(!lo));
         chk(busy == (t < fend), "R9 busy during acquire", int'(busy), int'(t < fend));
         chk(cpu_disable == 1'b1, "R2 disable held", int'(cpu_disable), 1);
         if (lo) chk(addr_bus == a + 16'(k), "R6 address", int'(addr_bus), int'(a + 16'(k)));
         chk(data_valid == vv, "R7 valid pulse", int'(data_valid), int'(vv));
         if (vv) begin
            chk(data_out == memf(a + 16'(k)), "R7 captured data", int'(data_out), int'(memf(a + 16'(k))));
            @(negedge clk);
            chk(data_valid == 1'b0, "R7 valid one clock", int'(data_valid), 0);
         end
      end
   endtask

   task automatic run_rel(input logic [2:0] ph, input bit noise);
      int r;
      r = exp_rel(ph);
      tk(1'b1, ph, '0, '0);
      chk(addr_oe == 1'b0, "R8 oe off at accept", int'(addr_oe), 0);
      chk(cpu_disable == 1'b1, "R8 disable still high", int'(cpu_disable), 1);
      chk(busy == 1'b1, "R9 busy at release accept", int'(busy), 1);
      for (int t = 1; t <= r; t++) begin
         gap();
         tk(noise && ($urandom % 3 == 0), 3'($urandom), 16'($urandom), 4'($urandom));
         chk(cpu_disable == (t < r), "R8 disable fall", int'(cpu_disable), int'(t < r));
         chk(busy == (t < r), "R9 busy during release", int'(busy), int'(t < r));
         chk(addr_oe == 1'b0, "R10 oe stays off", int'(addr_oe), 0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL R9 watchdog expired actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      chk(cpu_disable == 1'b0 && addr_oe == 1'b0, "R1 reset bus lines", int'({cpu_disable, addr_oe}), 0);
      chk(rd_n == 1'b1, "R1 reset strobe", int'(rd_n), 1);
      chk(busy == 1'b0 && data_valid == 1'b0 && err == 1'b0, "R1 reset flags",
          int'({busy, data_valid, err}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: request without tick is ignored
      cmd_valid = 1'b1; cmd_phase = 3'd0;
      @(negedge clk);
      cmd_valid = 1'b0;
      @(negedge clk);
      chk(busy == 1'b0 && cpu_disable == 1'b0, "R2 no tick no accept", int'({busy, cpu_disable}), 0);

      // R3: directed pass through every region, acquire then release
      run_acq(3'd0, 16'h1000, 4'd0, 1'b0);
      run_rel(3'd1, 1'b0);
      run_acq(3'd2, 16'hFFFE, 4'd3, 1'b1);
      run_rel(3'd3, 1'b1);
      run_acq(3'd4, 16'h2340, 4'd15, 1'b1);
      run_rel(3'd5, 1'b0);
      run_acq(3'd6, 16'h8001, 4'd1, 1'b0);
      run_rel(3'd7, 1'b1);

      // constrained random rounds
      for (int i = 0; i < 10; i++) begin
         logic [1:0] rg;
         rg = 2'($urandom);
         run_acq({rg, 1'b0}, 16'($urandom), 4'($urandom % 8), 1'b1);
         rg = 2'($urandom);
         run_rel({rg, 1'b1}, 1'b1);
      end

      @(negedge clk);
      chk(err == 1'b0, "R10 no contention flag", int'(err), 0);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule